// File: doc/BRIEF.md
# DMA Channel Status Word

This block keeps the read-only 32-bit status word of one DMA channel. A small set of sticky flags lives here: the temporary interrupt mask, the descriptor error flag and the descriptor writeback flag. Control strobes, descriptor load events and header-writeback events set and clear these flags. The channel mode bit and the remaining status bits come from elsewhere in the channel. They are merged into the word as live values.

The block also gates the transfer-end interrupt. While the mask flag is up, a transfer-end event is held as pending. It is released when the mask drops, unless a software reset discards it first. When a descriptor error is flagged, a stop request is raised towards the transfer engine. No error interrupt is raised for that case.

Top module: `dmastat_top`

## Requirements
- R1: Bits 31..17 and 15..12 of `statusWord` always read 0.
- R2: Bit 16 (mask) becomes 1 one clock after a `setMaskPulse`. It becomes 0 one clock after a `clrMaskPulse`. If both pulses arrive in the same cycle, the clear wins.
- R3: Bit 11 always equals `cfgLinkMode` in the same cycle (0 = register mode, 1 = link mode).
- R4: Bit 10 (descriptor error) becomes 1 one clock after a `descLoad` with `descLinkValid`=0 while `cfgLinkMode`=1. A load in register mode, or a load with `descLinkValid`=1, leaves it unchanged. Once set, only software reset clears it.
- R5: `stopReq` is 1 exactly while bit 10 is 1.
- R6: Bit 9 (writeback) becomes 1 one clock after `wbStart` in link mode. `wbStart` in register mode has no effect on it. It clears one clock after `wbDone` with `wbBusError`=0. It stays 1 after `wbDone` with `wbBusError`=1. A start and an OK end in the same cycle leave it set.
- R7: With the mask at 0, a `xferEndPulse` gives a one-cycle `xferEndIrq` pulse one clock later. While bit 16 is 1, `xferEndIrq` is 0.
- R8: A transfer-end event that arrives while masked is kept. `xferEndIrq` pulses for one cycle in the first cycle after the mask drops to 0.
- R9: `swResetPulse` clears the mask, descriptor error, writeback flag and any pending transfer-end event one clock later. It wins over every set condition in the same cycle.
- R10: Bits 8..5 show `dlIn`, `srIn`, `tcIn`, `endIn` (bit 8 down to bit 5). Bit 4 shows `errIn`. Bits 3..0 show `susIn`, `tactIn`, `rqstIn`, `enIn` (bit 3 down to bit 0). All of these are live in the same cycle.
- R11: After reset every flag, `stopReq` and `xferEndIrq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| setMaskPulse | input | 1 | Set the temporary interrupt mask |
| clrMaskPulse | input | 1 | Clear the temporary interrupt mask |
| swResetPulse | input | 1 | Software reset of the channel flags |
| cfgLinkMode | input | 1 | Configured mode, 1 = link mode |
| descLoad | input | 1 | Descriptor loaded this cycle |
| descLinkValid | input | 1 | Link-valid field of the loaded descriptor |
| wbStart | input | 1 | Header writeback begins |
| wbDone | input | 1 | Header writeback response received |
| wbBusError | input | 1 | Response of `wbDone` is a bus error |
| xferEndPulse | input | 1 | Transfer-end event |
| errIn | input | 1 | Channel error status |
| dlIn | input | 1 | Status input shown at bit 8 |
| srIn | input | 1 | Status input shown at bit 7 |
| tcIn | input | 1 | Terminal count status |
| endIn | input | 1 | Transfer end status |
| susIn | input | 1 | Suspend status |
| tactIn | input | 1 | Transfer active status |
| rqstIn | input | 1 | Request status |
| enIn | input | 1 | Channel enable status |
| statusWord | output | 32 | Composed status word |
| stopReq | output | 1 | Stop request after a descriptor error |
| xferEndIrq | output | 1 | Gated transfer-end interrupt pulse |

## Verification
All flag state appears directly on `statusWord` one clock after the event that changes it. A wrong set or clear rule therefore shows up in the very next cycle. A lost or duplicated pending transfer-end event shows only on `xferEndIrq`: either no pulse, or an extra pulse, in the first cycle after the mask drops. The directed tests cover these cases:
- mask, reset and load collisions in a single cycle;
- descriptor loads in both modes;
- a writeback ending OK and one ending in a bus error;
- events hidden behind the mask, released by an unmask or discarded by a software reset.

// File: rtl/dmastat_pkg.sv
package dmastat_pkg;
  localparam int STAT_W   = 32;
  localparam int POS_MASK = 16;
  localparam int POS_MODE = 11;
  localparam int POS_DERR = 10;
  localparam int POS_WB   = 9;
  localparam int POS_DL   = 8;
  localparam int POS_SR   = 7;
  localparam int POS_TC   = 6;
  localparam int POS_END  = 5;
  localparam int POS_ERR  = 4;
  localparam int POS_SUS  = 3;
  localparam int POS_TACT = 2;
  localparam int POS_RQST = 1;
  localparam int POS_EN   = 0;

  typedef struct packed {
    logic clrAll;
    logic maskSet;
    logic maskClr;
    logic derSet;
    logic wbSet;
    logic wbClr;
    logic pendSet;
  } stat_strobe_t;
endpackage

// File: rtl/dmastat_ctrl.sv
module dmastat_ctrl
  import dmastat_pkg::*;
(
  input  logic         setMaskPulse,
  input  logic         clrMaskPulse,
  input  logic         swResetPulse,
  input  logic         cfgLinkMode,
  input  logic         descLoad,
  input  logic         descLinkValid,
  input  logic         wbStart,
  input  logic         wbDone,
  input  logic         wbBusError,
  input  logic         xferEndPulse,
  output stat_strobe_t strobes
);
  logic badDesc;
  logic wbOk;

  // A descriptor error is judged only on the link-valid field.
  // The descriptor's interrupt setting plays no part.
  assign badDesc = descLoad & cfgLinkMode & ~descLinkValid;
  assign wbOk    = wbDone & ~wbBusError;

  always_comb begin
    strobes         = '0;
    strobes.clrAll  = swResetPulse;
    if (!swResetPulse) begin
      strobes.maskClr = clrMaskPulse;
      strobes.maskSet = setMaskPulse & ~clrMaskPulse;
      strobes.derSet  = badDesc;
      strobes.wbSet   = wbStart & cfgLinkMode;
      strobes.wbClr   = wbOk & ~(wbStart & cfgLinkMode);
      strobes.pendSet = xferEndPulse;
    end
  end
endmodule

// File: rtl/dmastat_dp.sv
module dmastat_dp
  import dmastat_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  stat_strobe_t strobes,
  output logic         maskBit,
  output logic         derBit,
  output logic         wbBit,
  output logic         irqOut
);
  logic maskQ, derQ, wbQ, pendQ;
  logic release_;

  // A pending event leaves in the first cycle without the mask.
  assign release_ = pendQ & ~maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= 1'b0;
      derQ  <= 1'b0;
      wbQ   <= 1'b0;
      pendQ <= 1'b0;
    end else if (strobes.clrAll) begin
      maskQ <= 1'b0;
      derQ  <= 1'b0;
      wbQ   <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (strobes.maskSet)      maskQ <= 1'b1;
      else if (strobes.maskClr) maskQ <= 1'b0;
      if (strobes.derSet)       derQ  <= 1'b1;
      if (strobes.wbSet)        wbQ   <= 1'b1;
      else if (strobes.wbClr)   wbQ   <= 1'b0;
      pendQ <= strobes.pendSet | (pendQ & ~release_);
    end
  end

  assign maskBit = maskQ;
  assign derBit  = derQ;
  assign wbBit   = wbQ;
  assign irqOut  = release_;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    maskQ |-> !irqOut); // R7
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !strobes.pendSet) |=> !irqOut); // R8
endmodule

// File: rtl/dmastat_top.sv
module dmastat_top
  import dmastat_pkg::*;
#(
  parameter int WORD_W = STAT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setMaskPulse,
  input  logic              clrMaskPulse,
  input  logic              swResetPulse,
  input  logic              cfgLinkMode,
  input  logic              descLoad,
  input  logic              descLinkValid,
  input  logic              wbStart,
  input  logic              wbDone,
  input  logic              wbBusError,
  input  logic              xferEndPulse,
  input  logic              errIn,
  input  logic              dlIn,
  input  logic              srIn,
  input  logic              tcIn,
  input  logic              endIn,
  input  logic              susIn,
  input  logic              tactIn,
  input  logic              rqstIn,
  input  logic              enIn,
  output logic [WORD_W-1:0] statusWord,
  output logic              stopReq,
  output logic              xferEndIrq
);
  stat_strobe_t strobes;
  logic maskBit, derBit, wbBit;

  dmastat_ctrl uCtrl (
    .setMaskPulse (setMaskPulse),
    .clrMaskPulse (clrMaskPulse),
    .swResetPulse (swResetPulse),
    .cfgLinkMode  (cfgLinkMode),
    .descLoad     (descLoad),
    .descLinkValid(descLinkValid),
    .wbStart      (wbStart),
    .wbDone       (wbDone),
    .wbBusError   (wbBusError),
    .xferEndPulse (xferEndPulse),
    .strobes      (strobes)
  );

  dmastat_dp uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .maskBit(maskBit),
    .derBit (derBit),
    .wbBit  (wbBit),
    .irqOut (xferEndIrq)
  );

  always_comb begin
    statusWord           = '0;
    statusWord[POS_MASK] = maskBit;
    statusWord[POS_MODE] = cfgLinkMode;
    statusWord[POS_DERR] = derBit;
    statusWord[POS_WB]   = wbBit;
    statusWord[POS_DL]   = dlIn;
    statusWord[POS_SR]   = srIn;
    statusWord[POS_TC]   = tcIn;
    statusWord[POS_END]  = endIn;
    statusWord[POS_ERR]  = errIn;
    statusWord[POS_SUS]  = susIn;
    statusWord[POS_TACT] = tactIn;
    statusWord[POS_RQST] = rqstIn;
    statusWord[POS_EN]   = enIn;
  end

  // A descriptor error halts the channel. No error interrupt is raised.
  assign stopReq = derBit;

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    (setMaskPulse && !clrMaskPulse && !swResetPulse) |=> statusWord[POS_MASK]); // R2
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    clrMaskPulse |=> !statusWord[POS_MASK]); // R2
  AST_DERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[POS_DERR] && !swResetPulse) |=> statusWord[POS_DERR]); // R4
  AST_WB_BUSERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[POS_WB] && wbDone && wbBusError && !swResetPulse) |=> statusWord[POS_WB]); // R6
  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    swResetPulse |=> (!statusWord[POS_MASK] && !statusWord[POS_DERR] && !statusWord[POS_WB] && !xferEndIrq)); // R9
endmodule

// File: tb/dmastat_top_test.sv
module dmastat_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setMaskPulse = 0, clrMaskPulse = 0, swResetPulse = 0, cfgLinkMode = 0;
  logic descLoad = 0, descLinkValid = 0, wbStart = 0, wbDone = 0, wbBusError = 0;
  logic xferEndPulse = 0, errIn = 0, dlIn = 0, srIn = 0, tcIn = 0, endIn = 0;
  logic susIn = 0, tactIn = 0, rqstIn = 0, enIn = 0;
  logic [31:0] statusWord;
  logic stopReq, xferEndIrq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dmastat_top uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    setMaskPulse = 0; clrMaskPulse = 0; swResetPulse = 0;
    descLoad = 0; descLinkValid = 0; wbStart = 0; wbDone = 0; wbBusError = 0;
    xferEndPulse = 0;
  endtask

  // Inputs are driven 1 ns after a rising edge.
  // Each step passes one edge, then clears the pulses.
  task automatic step();
    @(posedge clk); #1;
    clearIn();
  endtask

  task automatic swReset();
    swResetPulse = 1; step();
  endtask

  task automatic tReset();
    check("R11 word", statusWord, 32'h0);
    check("R11 stopReq", {31'b0, stopReq}, 32'h0);
    check("R11 irq", {31'b0, xferEndIrq}, 32'h0);
  endtask

  task automatic tPassAndMode();
    cfgLinkMode = 1; errIn = 1; dlIn = 1; srIn = 1; tcIn = 1; endIn = 1;
    susIn = 1; tactIn = 1; rqstIn = 1; enIn = 1; #1;
    check("R3 mode=1", {31'b0, statusWord[11]}, 32'h1);
    check("R10 all ones", statusWord & 32'h1FF, 32'h1FF);
    check("R1 reserved zero", statusWord & 32'hFFFE_F000, 32'h0);
    cfgLinkMode = 0; dlIn = 0; tcIn = 0; errIn = 0; tactIn = 0; enIn = 0; #1;
    check("R3 mode=0", {31'b0, statusWord[11]}, 32'h0);
    check("R10 pattern", statusWord & 32'h1FF, 32'h0AA);
    srIn = 0; endIn = 0; susIn = 0; rqstIn = 0; #1;
  endtask

  task automatic tMask();
    setMaskPulse = 1; clrMaskPulse = 1; step();
    check("R2 clear wins", {31'b0, statusWord[16]}, 32'h0);
    setMaskPulse = 1; step();
    check("R2 set", {31'b0, statusWord[16]}, 32'h1);
    check("R1 reserved with mask", statusWord & 32'hFFFE_F000, 32'h0);
    setMaskPulse = 1; clrMaskPulse = 1; step();
    check("R2 clear wins when set", {31'b0, statusWord[16]}, 32'h0);
    setMaskPulse = 1; step();
    swResetPulse = 1; setMaskPulse = 1; step();
    check("R9 reset beats set", {31'b0, statusWord[16]}, 32'h0);
  endtask

  task automatic tIrq();
    xferEndPulse = 1; step();
    check("R7 irq pulse", {31'b0, xferEndIrq}, 32'h1);
    step();
    check("R7 irq one cycle", {31'b0, xferEndIrq}, 32'h0);
    setMaskPulse = 1; step();
    xferEndPulse = 1; step();
    check("R7 masked low", {31'b0, xferEndIrq}, 32'h0);
    step(); step();
    check("R8 still held", {31'b0, xferEndIrq}, 32'h0);
    clrMaskPulse = 1; step();
    check("R8 released", {31'b0, xferEndIrq}, 32'h1);
    step();
    check("R8 released once", {31'b0, xferEndIrq}, 32'h0);
    setMaskPulse = 1; step();
    xferEndPulse = 1; step();
    swReset();
    clrMaskPulse = 1; step();
    check("R9 pending discarded", {31'b0, xferEndIrq}, 32'h0);
    xferEndPulse = 1; swResetPulse = 1; step();
    check("R9 reset beats event", {31'b0, xferEndIrq}, 32'h0);
  endtask

  task automatic tDesc();
    cfgLinkMode = 0; descLoad = 1; descLinkValid = 0; step();
    check("R4 register mode ignored", {31'b0, statusWord[10]}, 32'h0);
    cfgLinkMode = 1; descLoad = 1; descLinkValid = 1; step();
    check("R4 valid link ignored", {31'b0, statusWord[10]}, 32'h0);
    descLoad = 1; descLinkValid = 0; swResetPulse = 1; step();
    check("R9 reset beats desc error", {31'b0, statusWord[10]}, 32'h0);
    descLoad = 1; descLinkValid = 0; step();
    check("R4 set", {31'b0, statusWord[10]}, 32'h1);
    check("R5 stop", {31'b0, stopReq}, 32'h1);
    setMaskPulse = 1; clrMaskPulse = 1; descLoad = 1; descLinkValid = 1; step();
    step();
    check("R4 sticky", {31'b0, statusWord[10]}, 32'h1);
    swReset();
    check("R4 cleared by reset", {31'b0, statusWord[10]}, 32'h0);
    check("R5 stop dropped", {31'b0, stopReq}, 32'h0);
  endtask

  task automatic tWriteback();
    cfgLinkMode = 0; wbStart = 1; step();
    check("R6 register mode ignored", {31'b0, statusWord[9]}, 32'h0);
    cfgLinkMode = 1; wbStart = 1; step();
    check("R6 start", {31'b0, statusWord[9]}, 32'h1);
    wbDone = 1; step();
    check("R6 ok end clears", {31'b0, statusWord[9]}, 32'h0);
    wbStart = 1; step();
    wbDone = 1; wbBusError = 1; errIn = 1; step();
    check("R6 bus error holds", {31'b0, statusWord[9]}, 32'h1);
    check("R10 error bit", {31'b0, statusWord[4]}, 32'h1);
    step();
    check("R6 still failed", statusWord & 32'h210, 32'h210);
    swReset();
    errIn = 0; #1;
    check("R9 writeback cleared", {31'b0, statusWord[9]}, 32'h0);
    wbStart = 1; swResetPulse = 1; step();
    check("R9 reset beats start", {31'b0, statusWord[9]}, 32'h0);
    cfgLinkMode = 0; #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #7 rstN = 1;
    @(posedge clk); #1;
    tReset();
    tPassAndMode();
    tMask();
    tIrq();
    tDesc();
    tWriteback();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule